// File: doc/BRIEF.md
# Digital Window-Centre Phase Tracker

This block tracks the phase of a sampled serial data stream purely in the digital domain. A separate sampler reports, once per bit period, whether it saw a valid data edge and at which of 32 equally spaced oscillator taps that edge fell. The tracker holds the tap index it treats as the middle of the current data window. It steers that index towards the reported edges through a first-order digital lowpass filter.

Each clock cycle is one bit period. When an edge is reported, the tap distance from the window middle to the edge is taken modulo the tap count and read as a signed error. The error is scaled down by a run-time selectable power of two and added to a fractional accumulator. Only a whole-tap overflow of the accumulator moves the window middle, and it moves by a single tap. A zero-phase-start arm makes the next reported edge load the window middle directly. The window edges come from the middle, a programmable offset and a programmable width, and are registered outputs.

Top module: `wcenter_track`

## Requirements
- R1: While `rst` is high, `center_tap`, `edge_lo` and `edge_hi` read 0, the fractional accumulator is cleared and zero-phase start is armed.
- R2: The phase error is `(trans_tap - center_tap) mod 32`, read as a signed value from -16 to +15. An edge exactly 16 taps away therefore counts as -16.
- R3: On an unarmed valid edge, the accumulator (4 fractional bits, one tap = 16) takes `sum = acc + floor(err*16 / 2^k)`. If `sum >= 16`, the centre advances by one tap and the accumulator keeps `min(sum-16, 15)`. If `sum <= -16`, the centre retreats by one tap and the accumulator keeps `max(sum+16, -15)`. Otherwise the accumulator keeps `sum`.
- R4: The centre moves by at most one tap per bit period and wraps modulo 32 in both directions (31 to 0, 0 to 31).
- R5: In a cycle with `trans_valid` low, neither the centre nor the accumulator changes, whatever `trans_tap` and `shift_k` carry.
- R6: A cycle with `trans_valid` high while zero-phase start is armed (or while `zps_req` is high) loads `center_tap` with `trans_tap`, clears the accumulator and disarms. `zps_req` without a valid edge arms the mode.
- R7: `shift_k` selects k at run time. Values 0 to 4 are used as given, and values 5 to 7 act as 4.
- R8: Every cycle out of reset, `edge_lo` becomes `(c + win_offset - (win_width>>1)) mod 32` and `edge_hi` becomes `(c + win_offset + (win_width>>1)) mod 32`, where c is the centre value written in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-period clock |
| rst | input | 1 | Synchronous active-high reset |
| trans_valid | input | 1 | A valid data edge was found this bit period |
| trans_tap | input | 5 | Tap index at which the edge was found |
| zps_req | input | 1 | Arm zero-phase start |
| shift_k | input | 3 | Loop time constant selector (right shift of the error) |
| win_width | input | 5 | Window width in taps |
| win_offset | input | 5 | Window offset in taps |
| center_tap | output | 5 | Current window-centre tap |
| edge_lo | output | 5 | Lower window edge tap |
| edge_hi | output | 5 | Upper window edge tap |

## Verification
Every result of this block is due one clock after the inputs that cause it. The centre register and both edge registers update on the rising edge that samples the edge report, the arm request and the window controls. The bench therefore drives each bit period's inputs after a falling edge and lets one rising edge pass. It then compares all three outputs at the following falling edge against an integer model advanced for that same rising edge. The accumulator is not visible at the ports. Its effect is checked through the exact cycle at which a later centre step appears during the long mixed run.

// File: rtl/wct_pkg.sv
package wct_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

endpackage

// File: rtl/wct_phase_err.sv
module wct_phase_err #(
  parameter int TAP_W = 5
) (
  input  logic [TAP_W-1:0]        center,
  input  logic [TAP_W-1:0]        trans_tap,
  output logic signed [TAP_W-1:0] err
);

  logic [TAP_W-1:0] diff;

  // Wrap-around distance, reinterpreted as two's complement.
  always_comb begin
    diff = trans_tap - center;
    err  = signed'(diff);
  end

endmodule

// File: rtl/wct_loop_filter.sv
module wct_loop_filter
  import wct_pkg::*;
#(
  parameter int TAP_W  = 5,
  parameter int FRAC_W = 4,
  parameter int K_MAX  = 4,
  parameter int K_W    = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    clr,
  input  logic signed [TAP_W-1:0] err,
  input  logic [K_W-1:0]          shift_k,
  output step_e                   step
);

  localparam int ACC_W = TAP_W + FRAC_W + 1;
  localparam logic signed [ACC_W-1:0] ONE     = ACC_W'(1 << FRAC_W);
  localparam logic signed [ACC_W-1:0] NEG_ONE = -ONE;
  localparam logic signed [ACC_W-1:0] LIM_P   = ONE - ACC_W'(1);
  localparam logic signed [ACC_W-1:0] LIM_N   = -LIM_P;

  logic signed [ACC_W-1:0] acc_q, acc_d;
  logic signed [ACC_W-1:0] err_x, scaled, sum, rem;
  logic [K_W-1:0]          k_eff;

  always_comb begin
    k_eff  = (shift_k > K_W'(K_MAX)) ? K_W'(K_MAX) : shift_k;
    err_x  = {{(ACC_W-TAP_W){err[TAP_W-1]}}, err};
    scaled = (err_x <<< FRAC_W) >>> k_eff;
    sum    = acc_q + scaled;
    step   = STEP_HOLD;
    rem    = sum;
    acc_d  = acc_q;
    if (en) begin
      if (sum >= ONE) begin
        step  = STEP_UP;
        rem   = sum - ONE;
        acc_d = (rem > LIM_P) ? LIM_P : rem;
      end else if (sum <= NEG_ONE) begin
        step  = STEP_DOWN;
        rem   = sum + ONE;
        acc_d = (rem < LIM_N) ? LIM_N : rem;
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) acc_q <= '0;
    else            acc_q <= acc_d;
  end

  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (rst)
    (acc_q > NEG_ONE) && (acc_q < ONE)); // R3
  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(acc_q)); // R5
  AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc_q == '0)); // R6

endmodule

// File: rtl/wct_window.sv
module wct_window #(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TAP_W-1:0] center_d,
  input  logic [TAP_W-1:0] width,
  input  logic [TAP_W-1:0] offset,
  output logic [TAP_W-1:0] edge_lo,
  output logic [TAP_W-1:0] edge_hi
);

  logic [TAP_W-1:0] mid, half, span;

  always_comb begin
    half = width >> 1;
    mid  = center_d + offset;
    span = edge_hi - edge_lo;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_lo <= '0;
      edge_hi <= '0;
    end else begin
      edge_lo <= mid - half;
      edge_hi <= mid + half;
    end
  end

  AST_EDGE_SPAN: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (span == TAP_W'({$past(width) >> 1, 1'b0}))); // R8

endmodule

// File: rtl/wcenter_track.sv
module wcenter_track
  import wct_pkg::*;
#(
  parameter int TAPS   = 32,
  parameter int FRAC_W = 4,
  parameter int K_MAX  = 4,
  parameter int K_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     trans_valid,
  input  logic [$clog2(TAPS)-1:0]  trans_tap,
  input  logic                     zps_req,
  input  logic [K_W-1:0]           shift_k,
  input  logic [$clog2(TAPS)-1:0]  win_width,
  input  logic [$clog2(TAPS)-1:0]  win_offset,
  output logic [$clog2(TAPS)-1:0]  center_tap,
  output logic [$clog2(TAPS)-1:0]  edge_lo,
  output logic [$clog2(TAPS)-1:0]  edge_hi
);

  localparam int TAP_W = $clog2(TAPS);

  logic                    armed_q;
  logic                    load;
  logic [TAP_W-1:0]        center_d;
  logic signed [TAP_W-1:0] err;
  step_e                   step;

  wct_phase_err #(.TAP_W(TAP_W)) u_err (
    .center    (center_tap),
    .trans_tap (trans_tap),
    .err       (err)
  );

  wct_loop_filter #(
    .TAP_W  (TAP_W),
    .FRAC_W (FRAC_W),
    .K_MAX  (K_MAX),
    .K_W    (K_W)
  ) u_filt (
    .clk     (clk),
    .rst     (rst),
    .en      (trans_valid && !load),
    .clr     (load),
    .err     (err),
    .shift_k (shift_k),
    .step    (step)
  );

  always_comb begin
    load = trans_valid && (armed_q || zps_req);
    if (load) center_d = trans_tap;
    else begin
      case (step)
        STEP_UP:   center_d = center_tap + TAP_W'(1);
        STEP_DOWN: center_d = center_tap - TAP_W'(1);
        default:   center_d = center_tap;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      center_tap <= '0;
      armed_q    <= 1'b1;
    end else begin
      center_tap <= center_d;
      if (load)         armed_q <= 1'b0;
      else if (zps_req) armed_q <= 1'b1;
    end
  end

  wct_window #(.TAP_W(TAP_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .center_d (center_d),
    .width    (win_width),
    .offset   (win_offset),
    .edge_lo  (edge_lo),
    .edge_hi  (edge_hi)
  );

  AST_ONE_TAP_STEP: assert property (@(posedge clk) disable iff (rst)
    (trans_valid && !armed_q && !zps_req) |=>
      (center_tap == $past(center_tap) ||
       center_tap == TAP_W'($past(center_tap) + TAP_W'(1)) ||
       center_tap == TAP_W'($past(center_tap) - TAP_W'(1)))); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !trans_valid |=> $stable(center_tap)); // R5
  AST_ZPS_LOAD: assert property (@(posedge clk) disable iff (rst)
    (trans_valid && (armed_q || zps_req)) |=> (center_tap == $past(trans_tap))); // R6
  AST_RESET_VALUE: assert property (@(posedge clk)
    rst |=> (center_tap == '0)); // R1

endmodule

// File: tb/wcenter_track_bench.sv
module wcenter_track_bench;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       trans_valid;
  logic [4:0] trans_tap;
  logic       zps_req;
  logic [2:0] shift_k;
  logic [4:0] win_width;
  logic [4:0] win_offset;
  logic [4:0] center_tap, edge_lo, edge_hi;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  int m_c, m_acc, m_lo, m_hi;
  bit m_arm;

  always #(CLK_P/2) clk = ~clk;

  wcenter_track u_wcenter_track (
    .clk         (clk),
    .rst         (rst),
    .trans_valid (trans_valid),
    .trans_tap   (trans_tap),
    .zps_req     (zps_req),
    .shift_k     (shift_k),
    .win_width   (win_width),
    .win_offset  (win_offset),
    .center_tap  (center_tap),
    .edge_lo     (edge_lo),
    .edge_hi     (edge_hi)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // Integer reference of one bit period.
  task automatic model(input bit v, input int tap, input bit z, input int k,
                       input int w, input int o);
    int e, kk, sum;
    if (v && (m_arm || z)) begin
      m_c = tap; m_acc = 0; m_arm = 0;
    end else begin
      if (z) m_arm = 1;
      if (v) begin
        e = (tap - m_c) & 31;
        if (e >= 16) e -= 32;
        kk = (k > 4) ? 4 : k;
        sum = m_acc + ((e * 16) >>> kk);
        if (sum >= 16) begin
          m_c = (m_c + 1) & 31;
          m_acc = (sum - 16 > 15) ? 15 : sum - 16;
        end else if (sum <= -16) begin
          m_c = (m_c + 31) & 31;
          m_acc = (sum + 16 < -15) ? -15 : sum + 16;
        end else m_acc = sum;
      end
    end
    m_lo = (m_c + o - (w >> 1)) & 31;
    m_hi = (m_c + o + (w >> 1)) & 31;
  endtask

  task automatic cyc(input bit v, input int tap, input bit z, input int k,
                     input int w, input int o, input string creq);
    trans_valid = v; trans_tap = 5'(tap); zps_req = z;
    shift_k = 3'(k); win_width = 5'(w); win_offset = 5'(o);
    @(posedge clk);
    model(v, tap, z, k, w, o);
    @(negedge clk);
    chk(int'(center_tap), m_c, creq, "center_tap");
    chk(int'(edge_lo), m_lo, "R8", "edge_lo");
    chk(int'(edge_hi), m_hi, "R8", "edge_hi");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    string rq;
    int seed, v, tap, z, k, w, o;
    rst = 1'b1; trans_valid = 0; trans_tap = 0; zps_req = 0;
    shift_k = 0; win_width = 5'd6; win_offset = 5'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(int'(center_tap), 0, "R1", "reset center_tap");
    chk(int'(edge_lo), 0, "R1", "reset edge_lo");
    chk(int'(edge_hi), 0, "R1", "reset edge_hi");
    rst = 1'b0;
    m_c = 0; m_acc = 0; m_arm = 1;

    // Armed after reset: first edge loads directly (R6).
    cyc(1, 13, 0, 2, 6, 3, "R6");
    // Idle cycles with a far-away tap must not move anything (R5).
    for (int i = 0; i < 4; i++) cyc(0, 29 - i, 0, 0, 6, 3, "R5");
    // A 16-tap distance counts as negative: retreat (R2).
    cyc(1, 29, 0, 0, 6, 3, "R2");

    // Sweep every k, every start centre and every edge position.
    for (int kk = 0; kk < 8; kk++)
      for (int c = 0; c < 32; c++)
        for (int t = 0; t < 32; t++) begin
          cyc(1, c, 1, kk, (c * 3) & 31, t, "R6");
          if (kk > 4)                  rq = "R7";
          else if (c == 0 || c == 31)  rq = "R4";
          else if (((t - c) & 31) == 16) rq = "R2";
          else                         rq = "R3";
          cyc(1, t, 0, kk, (t * 5) & 31, c, rq);
        end

    // Long mixed run: accumulator history shows in step timing.
    seed = 7;
    for (int i = 0; i < 5000; i++) begin
      v   = ($urandom(seed) % 3) != 0;
      seed = seed + 1;
      tap = $urandom % 32;
      z   = ($urandom % 61) == 0;
      k   = $urandom % 8;
      w   = $urandom % 32;
      o   = $urandom % 32;
      cyc(v[0], tap, z[0], k, w, o, v ? "R3" : "R5");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule